// File: doc/BRIEF.md
# Hotplug Event Status and Eject Register Block

This block gathers hot-add and hot-remove notifications for PCI slots and processors and turns them into general-purpose event status for system firmware. Each event updates a set of bitmaps that software reads to learn which slot or CPU changed, sets a fixed bit in a 16-bit event status register, and raises the interrupt request when that bit is also set in a 16-bit enable register. Both 16-bit registers are written and read one byte at a time.

Software acknowledges a removal by writing a mask to an eject register. The block decodes the mask to the index of its lowest set bit and emits a one-cycle eject-done pulse carrying that slot number, which the slot logic uses to complete the removal.

The register port is a simple synchronous byte/word port: a write takes effect at the clock edge where `wr_en` is high, and `rd_data` reflects the register selected by `addr` combinationally.

Top module: `hotplug_gpe`

## Requirements
- R1: After reset, every register, bitmap and output reads as zero: status, enable, slot-added, slot-removed and CPU-removed bitmaps, `irq`, `eject_valid`.
- R2: A write to address 0 replaces status bits 7:0 with `wr_data[7:0]`, a write to address 1 replaces status bits 15:8 with `wr_data[7:0]`; the other byte is kept. Reads at 0 and 1 return that byte in `rd_data[7:0]` with the upper bits zero.
- R3: Addresses 2 (bits 7:0) and 3 (bits 15:8) give the same byte-lane write and read behaviour for the enable register.
- R4: A PCI event clears both slot bitmaps and then sets bit `pci_evt_slot` of the slot-added bitmap when `pci_evt_add` is 1, or of the slot-removed bitmap when it is 0. Address 4 reads the slot-added bitmap, address 5 the slot-removed bitmap.
- R5: A CPU event with `cpu_evt_add` = 0 sets bit `cpu_evt_idx` of the CPU-removed bitmap; with `cpu_evt_add` = 1 it clears that bit. Address 6 reads the bitmap, zero-extended.
- R6: A PCI event sets status bit 1 and a CPU event sets status bit 2 at the same edge; when a software write to the status register lands in the same cycle, the event bit still ends up set.
- R7: `irq` is 1 exactly when some bit is set in both the status and enable registers, so clearing either the status bit or its enable deasserts it.
- R8: A write to address 7 with a non-zero value gives `eject_valid` = 1 for the following cycle only, with `eject_slot` equal to the index of the lowest set bit of `wr_data`.
- R9: A write of zero to address 7 produces no eject pulse; reads at address 7 return zero; writes to addresses 4, 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wr_data | input | 32 | Write data (byte registers use bits 7:0) |
| rd_data | output | 32 | Read data for the selected register |
| pci_evt_valid | input | 1 | PCI slot hotplug event |
| pci_evt_slot | input | 5 | Slot index of the PCI event |
| pci_evt_add | input | 1 | 1 = slot added, 0 = slot removed |
| cpu_evt_valid | input | 1 | Processor hotplug event |
| cpu_evt_idx | input | 3 | CPU index of the event |
| cpu_evt_add | input | 1 | 1 = CPU added, 0 = CPU removed |
| irq | output | 1 | Event interrupt request |
| eject_valid | output | 1 | One-cycle eject-done pulse |
| eject_slot | output | 5 | Slot reported with the eject pulse |

## Verification
The collision that matters is a hotplug event arriving in the same cycle as a software write to the status byte that holds its event bit, where the event must win. The random phase drives PCI events, CPU events and register writes independently each cycle, so all three fall together regularly, and a directed case writes zero to status address 0 in the very cycle a PCI event arrives. Every cycle the bench compares the read-back status, the bitmaps and `irq` against a model that applies the write first and the events after it.

// File: rtl/hotplug_gpe.sv
module hotplug_gpe #(
  parameter int SLOTS       = 32,
  parameter int CPUS        = 8,
  parameter int PCI_STS_BIT = 1,
  parameter int CPU_STS_BIT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               addr,
  input  logic [31:0]              wr_data,
  output logic [31:0]              rd_data,
  input  logic                     pci_evt_valid,
  input  logic [$clog2(SLOTS)-1:0] pci_evt_slot,
  input  logic                     pci_evt_add,
  input  logic                     cpu_evt_valid,
  input  logic [$clog2(CPUS)-1:0]  cpu_evt_idx,
  input  logic                     cpu_evt_add,
  output logic                     irq,
  output logic                     eject_valid,
  output logic [$clog2(SLOTS)-1:0] eject_slot
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [15:0]       gpe_sts, gpe_en;
  logic [SLOTS-1:0]  slot_up, slot_dn;
  logic [CPUS-1:0]   cpu_dn;
  logic [SLOT_W-1:0] ej_idx;
  logic              ej_hit;

  assign ej_hit = wr_en && addr == 3'd7 && |wr_data[SLOTS-1:0];
  assign irq    = |(gpe_sts & gpe_en);

  always_comb begin
    ej_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (wr_data[i]) ej_idx = SLOT_W'(i);
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = {24'h0, gpe_sts[7:0]};
      3'd1:    rd_data = {24'h0, gpe_sts[15:8]};
      3'd2:    rd_data = {24'h0, gpe_en[7:0]};
      3'd3:    rd_data = {24'h0, gpe_en[15:8]};
      3'd4:    rd_data = 32'(slot_up);
      3'd5:    rd_data = 32'(slot_dn);
      3'd6:    rd_data = 32'(cpu_dn);
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpe_sts     <= '0;
      gpe_en      <= '0;
      slot_up     <= '0;
      slot_dn     <= '0;
      cpu_dn      <= '0;
      eject_valid <= 1'b0;
      eject_slot  <= '0;
    end else begin
      eject_valid <= ej_hit;
      if (ej_hit) eject_slot <= ej_idx;
      if (wr_en) begin
        case (addr)
          3'd0: gpe_sts[7:0]  <= wr_data[7:0];
          3'd1: gpe_sts[15:8] <= wr_data[7:0];
          3'd2: gpe_en[7:0]   <= wr_data[7:0];
          3'd3: gpe_en[15:8]  <= wr_data[7:0];
          default: ;
        endcase
      end
      if (pci_evt_valid) begin
        slot_up <= '0;
        slot_dn <= '0;
        if (pci_evt_add) slot_up[pci_evt_slot] <= 1'b1;
        else             slot_dn[pci_evt_slot] <= 1'b1;
        gpe_sts[PCI_STS_BIT] <= 1'b1;
      end
      if (cpu_evt_valid) begin
        cpu_dn[cpu_evt_idx]  <= !cpu_evt_add;
        gpe_sts[CPU_STS_BIT] <= 1'b1;
      end
    end
  end

  AST_EJECT_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7 && wr_data == 32'h0) |=> !eject_valid); // R9
  AST_EJECT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eject_valid |-> $past(wr_en && addr == 3'd7 && wr_data != 32'h0)); // R8
  AST_PCI_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    pci_evt_valid |=> $countones({slot_up, slot_dn}) == 1); // R4
  AST_PCI_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pci_evt_valid |=> gpe_sts[PCI_STS_BIT]); // R6
  AST_CPU_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_evt_valid |=> gpe_sts[CPU_STS_BIT]); // R6
  AST_CPU_REMOVED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_evt_valid && !cpu_evt_add) |=> cpu_dn[$past(cpu_evt_idx)]); // R5
endmodule

// File: tb/hotplug_gpe_tb.sv
module hotplug_gpe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pci_evt_valid = 1'b0;
  logic [4:0]  pci_evt_slot = '0;
  logic        pci_evt_add = 1'b0;
  logic        cpu_evt_valid = 1'b0;
  logic [2:0]  cpu_evt_idx = '0;
  logic        cpu_evt_add = 1'b0;
  logic        irq, eject_valid;
  logic [4:0]  eject_slot;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_sts, m_en;
  logic [31:0] m_up, m_dn;
  logic [7:0]  m_cpu;
  logic        m_ev;
  logic [4:0]  m_es;

  always #2 clk = ~clk;

  hotplug_gpe u_dut (
    .clk, .rst_n, .wr_en, .addr, .wr_data, .rd_data,
    .pci_evt_valid, .pci_evt_slot, .pci_evt_add,
    .cpu_evt_valid, .cpu_evt_idx, .cpu_evt_add,
    .irq, .eject_valid, .eject_slot
  );

  function automatic logic [4:0] lowbit(logic [31:0] d);
    logic [4:0] r = '0;
    for (int i = 31; i >= 0; i--) if (d[i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [31:0] mread(logic [2:0] a);
    case (a)
      3'd0: return {24'h0, m_sts[7:0]};
      3'd1: return {24'h0, m_sts[15:8]};
      3'd2: return {24'h0, m_en[7:0]};
      3'd3: return {24'h0, m_en[15:8]};
      3'd4: return m_up;
      3'd5: return m_dn;
      3'd6: return {24'h0, m_cpu};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4, 3'd5: return "R4";
      3'd6:       return "R5";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sts = '0; m_en = '0; m_up = '0; m_dn = '0; m_cpu = '0; m_ev = 1'b0; m_es = '0;
  endtask

  // Called at a negedge: drive, check current state, update model, move to next negedge.
  task automatic step(logic we, logic [2:0] a, logic [31:0] d,
                      logic pv, logic [4:0] ps, logic pa,
                      logic cv, logic [2:0] ci, logic ca);
    wr_en = we; addr = a; wr_data = d;
    pci_evt_valid = pv; pci_evt_slot = ps; pci_evt_add = pa;
    cpu_evt_valid = cv; cpu_evt_idx = ci; cpu_evt_add = ca;
    #1;
    check(rtag(a), rd_data, mread(a));
    check("R7", 32'(irq), 32'(|(m_sts & m_en)));
    check("R8", 32'(eject_valid), 32'(m_ev));
    if (m_ev) check("R8", 32'(eject_slot), 32'(m_es));
    m_ev = we && a == 3'd7 && d != 0;
    if (m_ev) m_es = lowbit(d);
    if (we) case (a)
      3'd0: m_sts[7:0]  = d[7:0];
      3'd1: m_sts[15:8] = d[7:0];
      3'd2: m_en[7:0]   = d[7:0];
      3'd3: m_en[15:8]  = d[7:0];
      default: ;
    endcase
    if (pv) begin
      m_up = '0; m_dn = '0;
      if (pa) m_up[ps] = 1'b1; else m_dn[ps] = 1'b1;
      m_sts[1] = 1'b1;
    end
    if (cv) begin
      m_cpu[ci] = !ca;
      m_sts[2] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic idle(logic [2:0] a);
    step(1'b0, a, 32'h0, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on every address and on irq/eject
    for (int a = 0; a < 8; a++) begin
      #1;
      addr = 3'(a);
      #1;
      check("R1", rd_data, 32'h0);
    end
    check("R1", 32'(irq), 32'h0);
    check("R1", 32'(eject_valid), 32'h0);
    @(negedge clk);

    // R6: PCI event collides with a zero write to status low byte
    step(1'b1, 3'd0, 32'h0, 1'b1, 5'd3, 1'b1, 1'b0, 3'd0, 1'b0);
    idle(3'd0);
    #1; check("R6", rd_data, 32'h02); @(negedge clk);
    // R6: CPU removal collides with write of 0 to status low byte
    step(1'b1, 3'd0, 32'h0, 1'b0, 5'd0, 1'b0, 1'b1, 3'd5, 1'b0);
    idle(3'd6);
    #1; check("R5", rd_data, 32'h20); @(negedge clk);
    addr = 3'd0; #1; check("R6", rd_data, 32'h04); @(negedge clk);
    // R7: enable bit 2 -> irq; clear status -> irq drops
    step(1'b1, 3'd2, 32'h04, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    idle(3'd0);
    #1; check("R7", 32'(irq), 32'h1); @(negedge clk);
    step(1'b1, 3'd0, 32'h0, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    idle(3'd0);
    #1; check("R7", 32'(irq), 32'h0); @(negedge clk);
    // R3: high enable byte does not disturb low byte
    step(1'b1, 3'd3, 32'hA5, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    idle(3'd2);
    #1; check("R3", rd_data, 32'h04); @(negedge clk);
    // R8 / R9: eject decode
    step(1'b1, 3'd7, 32'h0, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    #1; check("R9", 32'(eject_valid), 32'h0); @(negedge clk);
    step(1'b1, 3'd7, 32'h8000_0000, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    #1; check("R8", {31'h0, eject_valid} | (32'(eject_slot) << 8), 32'h1F01); @(negedge clk);
    step(1'b1, 3'd7, 32'h0000_0C00, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    #1; check("R8", 32'(eject_slot), 32'd10); @(negedge clk);
    idle(3'd7);
    #1; check("R8", 32'(eject_valid), 32'h0); @(negedge clk);
    // R9: writes to bitmap addresses ignored
    step(1'b1, 3'd4, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    step(1'b1, 3'd6, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    idle(3'd4);
    #1; check("R9", rd_data, 32'h0000_0008); @(negedge clk);
    addr = 3'd6; #1; check("R9", rd_data, 32'h20); @(negedge clk);

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic        we, pv, cv;
      logic [2:0]  a;
      logic [31:0] d;
      we = ($urandom % 10) < 3;
      pv = ($urandom % 10) < 2;
      cv = ($urandom % 10) < 2;
      a  = 3'($urandom);
      case ($urandom % 4)
        0: d = 32'h0;
        1: d = 32'h1 << ($urandom % 32);
        default: d = $urandom;
      endcase
      step(we, a, d, pv, 5'($urandom), 1'($urandom), cv, 3'($urandom), 1'($urandom));
    end
    idle(3'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule